// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block connects an 8-bit host processor to a small internal register file. Two static straps set how the host bus looks. One strap picks a shared address/data bus or a bus with separate address pins. The other strap gives the same three strobe pins either Intel-style meanings (read, write, address latch) or Motorola-style meanings (data strobe, read/write, address strobe). All pins are sampled on the block clock. A three-state access machine turns the sampled strobes into register reads and register writes.

The machine has three states. In `ST_IDLE` no access is in progress. In `ST_READ` the block drives the bus. In `ST_WRITE` the block holds the write data. The transitions are:

- `IDLE->READ` when a selected read strobe is seen.
- `IDLE->WRITE` when a selected write strobe is seen.
- `READ->IDLE` when the read strobe goes away.
- `WRITE->WRITE` while the write strobe stays active.
- `WRITE->IDLE` when the write strobe goes away. This transition commits the held byte into the register file.

The register space has 16 entries. The low twelve entries are writable control bytes. The top four entries are read-only status bytes supplied by the rest of the chip. A hardware reset clears every control byte.

Top module: `hbi_host_port`

## Requirements
- R1: While `rst_n` is low, all twelve control registers (addresses 0 to 11) are cleared to 0 asynchronously, the access state returns to idle, and `ad_oe` is low.
- R2: While `cs_n` is high, no register write takes effect and `ad_oe` stays low, whatever the strobe pins do.
- R3: With `bus_type` = 0 (Intel style):
  - `strb_a` is an active-low read strobe and `strb_b` is an active-low write strobe.
  - A write commits the byte that was on `ad_in` while `strb_b` was low. The commit happens when `strb_b` returns high.
  - If `strb_a` and `strb_b` are low together, the access is ignored.
- R4: With `bus_type` = 1 (Motorola style):
  - `strb_a` is an active-low data strobe and `strb_b` is read/write (1 = read, 0 = write).
  - A write commits when the data strobe returns high.
- R5: With `bus_sel` = 0 (shared bus):
  - The register address is `ad_in[3:0]`, captured when `strb_c` rises. `ad_in[7:4]` is ignored.
  - The captured address is kept for every later access until the next rise of `strb_c`.
- R6: With `bus_sel` = 1 (separate address pins):
  - The address is taken from `addr_in[3:0]` while a read or write strobe is active.
  - `strb_c` and the value on `ad_in` have no effect on the address.
- R7: `ad_oe` is high only during a selected read. While it is high, `ad_out` carries the byte at the current address. While `ad_oe` is low, `ad_out` is 0.
- R8: Reads of addresses 0 to 11 return the last byte written there. Address 12+k (k = 0 to 3) returns byte k of `stat_in`, where byte k is bits [8k+7:8k]. Writes to addresses 12 to 15 are ignored.
- R9: Read timing: `ad_oe` rises on the second clock edge after the read strobe is asserted and falls on the second edge after it is released. A read never leads directly into a write state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low hardware reset |
| bus_sel | input | 1 | Strap: 0 = shared address/data bus, 1 = separate address pins |
| bus_type | input | 1 | Strap: 0 = Intel strobes, 1 = Motorola strobes |
| cs_n | input | 1 | Active-low chip select |
| strb_a | input | 1 | Read strobe (Intel) or data strobe (Motorola), active low |
| strb_b | input | 1 | Write strobe (Intel, active low) or read/write select (Motorola) |
| strb_c | input | 1 | Address latch / address strobe; its rising edge captures the address |
| addr_in | input | 4 | Address pins used in separate-address mode |
| ad_in | input | 8 | Host data bus input (address and data in shared mode) |
| stat_in | input | 32 | Four status bytes read at addresses 12 to 15 |
| ad_out | output | 8 | Read data driven toward the host |
| ad_oe | output | 1 | Enable for the bus output drivers |

## Verification
A wrong address latch shows up as the wrong byte on `ad_out` in the first read after the faulty capture. Because every address is swept with a distinct pattern, the error shows within that one read. A wrong access state shows up in the read cycle itself:
- `ad_oe` rising one edge early or late, or staying up after the strobe is released.
- A write landing at the wrong time, at the wrong address, or not at all. The next readback of that register exposes it.

Missing chip-select gating, a misread strobe mapping in either bus style, or a status byte that a write could change each break the readback of a swept register within a few cycles.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } hbi_state_e;

    localparam logic BUS_SHARED   = 1'b0;
    localparam logic BUS_SPLIT    = 1'b1;
    localparam logic STROBE_INTEL = 1'b0;
    localparam logic STROBE_MOTO  = 1'b1;

endpackage

// File: rtl/hbi_strobe_decode.sv
module hbi_strobe_decode
    import hbi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_type,
    input  logic              cs_n,
    input  logic              strb_a,
    input  logic              strb_b,
    input  logic              strb_c,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              rd_act,
    output logic              wr_act,
    output logic              ale_rise,
    output logic [DATA_W-1:0] ad_s,
    output logic [ADDR_W-1:0] addr_s
);

    logic cs_s;
    logic a_s;
    logic b_s;
    logic c_s;
    logic c_d;

    // Sample every host pin once on the block clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s   <= 1'b1;
            a_s    <= 1'b1;
            b_s    <= 1'b1;
            c_s    <= 1'b0;
            c_d    <= 1'b0;
            ad_s   <= '0;
            addr_s <= '0;
        end else begin
            cs_s   <= cs_n;
            a_s    <= strb_a;
            b_s    <= strb_b;
            c_s    <= strb_c;
            c_d    <= c_s;
            ad_s   <= ad_in;
            addr_s <= addr_in;
        end
    end

    logic sel;
    assign sel = !cs_s;

    // Map the three strobe pins onto read and write requests.
    always_comb begin
        rd_act = 1'b0;
        wr_act = 1'b0;
        if (bus_type == STROBE_INTEL) begin
            rd_act = sel && !a_s && b_s;
            wr_act = sel && a_s && !b_s;
        end else begin
            rd_act = sel && !a_s && b_s;
            wr_act = sel && !a_s && !b_s;
        end
    end

    assign ale_rise = c_s && !c_d;

    // R2
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act || wr_act) |-> $past(!cs_n));

    // R3
    intel_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_type == STROBE_INTEL && $past(!strb_a && !strb_b)) |-> !(rd_act || wr_act));

endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              ale_rise,
    input  logic              acc_act,
    input  logic [ADDR_W-1:0] ad_lo,
    input  logic [ADDR_W-1:0] addr_s,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (bus_sel == BUS_SHARED) begin
            if (ale_rise) begin
                addr_q <= ad_lo;
            end
        end else begin
            if (acc_act) begin
                addr_q <= addr_s;
            end
        end
    end

    // R5
    shared_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == BUS_SHARED && !ale_rise) |=> $stable(addr_q));

    // R6
    split_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == BUS_SPLIT && !acc_act) |=> $stable(addr_q));

endmodule

// File: rtl/hbi_access_fsm.sv
module hbi_access_fsm
    import hbi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  logic              wr_act,
    input  logic [DATA_W-1:0] ad_s,
    output logic              data_oe,
    output logic              wr_en,
    output logic [DATA_W-1:0] wdata_q
);

    hbi_state_e state_q;
    hbi_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_act) begin
                    state_d = ST_READ;
                end else if (wr_act) begin
                    state_d = ST_WRITE;
                end
            end
            ST_READ: begin
                if (!rd_act) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (!wr_act) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Hold the byte seen during the last active write cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (wr_act) begin
            wdata_q <= ad_s;
        end
    end

    always_comb begin
        data_oe = 1'b0;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  data_oe = 1'b1;
            ST_WRITE: wr_en = !wr_act;
            default:  ;
        endcase
    end

    // R7
    oe_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(rd_act));

    // R9
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> (state_q != ST_WRITE));

    // R3
    commit_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(wr_act));

endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int NUM_STAT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [NUM_STAT*DATA_W-1:0] stat_in,
    output logic [DATA_W-1:0]          rd_data
);

    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int NUM_CTRL = NUM_REGS - NUM_STAT;

    logic [NUM_CTRL-1:0][DATA_W-1:0] rf_q;
    logic [NUM_CTRL-1:0]             hit;
    logic                            ctrl_sel;

    assign ctrl_sel = (addr < ADDR_W'(NUM_CTRL));

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
        assign hit[i] = wr_en && (addr == ADDR_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CTRL; i++) begin
                if (hit[i]) begin
                    rf_q[i] <= wr_data;
                end
            end
        end
    end

    logic [ADDR_W-1:0] sidx;
    assign sidx = addr - ADDR_W'(NUM_CTRL);

    always_comb begin
        if (ctrl_sel) begin
            rd_data = rf_q[addr];
        end else begin
            rd_data = stat_in[int'(sidx)*DATA_W +: DATA_W];
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_clear_chk: assert (rf_q == '0);
        end
    end

    // R8
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_sel) |=> (rf_q[$past(addr)] == $past(wr_data)));

    // R8
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl_sel) |=> $stable(rf_q));

endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int NUM_STAT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_type,
    input  logic                       cs_n,
    input  logic                       strb_a,
    input  logic                       strb_b,
    input  logic                       strb_c,
    input  logic [ADDR_W-1:0]          addr_in,
    input  logic [DATA_W-1:0]          ad_in,
    input  logic [NUM_STAT*DATA_W-1:0] stat_in,
    output logic [DATA_W-1:0]          ad_out,
    output logic                       ad_oe
);

    logic              rd_act;
    logic              wr_act;
    logic              ale_rise;
    logic [DATA_W-1:0] ad_s;
    logic [ADDR_W-1:0] addr_s;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_en;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_data;
    logic              data_oe;

    hbi_strobe_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_type (bus_type),
        .cs_n     (cs_n),
        .strb_a   (strb_a),
        .strb_b   (strb_b),
        .strb_c   (strb_c),
        .ad_in    (ad_in),
        .addr_in  (addr_in),
        .rd_act   (rd_act),
        .wr_act   (wr_act),
        .ale_rise (ale_rise),
        .ad_s     (ad_s),
        .addr_s   (addr_s)
    );

    hbi_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .ale_rise (ale_rise),
        .acc_act  (rd_act || wr_act),
        .ad_lo    (ad_s[ADDR_W-1:0]),
        .addr_s   (addr_s),
        .addr_q   (addr_q)
    );

    hbi_access_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_act  (rd_act),
        .wr_act  (wr_act),
        .ad_s    (ad_s),
        .data_oe (data_oe),
        .wr_en   (wr_en),
        .wdata_q (wdata_q)
    );

    hbi_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_STAT(NUM_STAT)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr_q),
        .wr_data (wdata_q),
        .stat_in (stat_in),
        .rd_data (rd_data)
    );

    assign ad_oe  = data_oe;
    assign ad_out = data_oe ? rd_data : '0;

    // R7
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |-> (ad_out == '0));

    // R1
    reset_oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !ad_oe);

endmodule

// File: tb/hbi_host_port_tb_top.sv
module hbi_host_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_type = 1'b0;
    logic        cs_n = 1'b1;
    logic        strb_a = 1'b1;
    logic        strb_b = 1'b1;
    logic        strb_c = 1'b0;
    logic [3:0]  addr_in = '0;
    logic [7:0]  ad_in = '0;
    logic [31:0] stat_in = 32'hD3C2B1A0;
    logic [7:0]  ad_out;
    logic        ad_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] model [16];

    always #4 clk = ~clk;

    hbi_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_type(bus_type),
        .cs_n(cs_n), .strb_a(strb_a), .strb_b(strb_b), .strb_c(strb_c),
        .addr_in(addr_in), .ad_in(ad_in), .stat_in(stat_in),
        .ad_out(ad_out), .ad_oe(ad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int m, input int a);
        return 8'((a * 29 + m * 71 + 3) & 8'hFF);
    endfunction

    function automatic logic [7:0] expect_rd(input int a);
        if (a >= 12) return stat_in[(a - 12) * 8 +: 8];
        return model[a];
    endfunction

    task automatic set_addr(input logic [3:0] a);
        if (bus_sel == 1'b0) begin
            ad_in  = {~a, a};
            strb_c = 1'b1;
            @(negedge clk);
            strb_c = 1'b0;
            @(negedge clk);
        end else begin
            addr_in = a;
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic csn);
        set_addr(a);
        cs_n  = csn;
        ad_in = d;
        strb_b = 1'b0;
        if (bus_type) begin
            @(negedge clk);
            strb_a = 1'b0;
        end
        repeat (2) @(negedge clk);
        if (bus_type) strb_a = 1'b1;
        else          strb_b = 1'b1;
        @(negedge clk);
        strb_b = 1'b1;
        cs_n   = 1'b1;
        repeat (2) @(negedge clk);
        if (!csn && a < 12) model[a] = d;
    endtask

    task automatic do_read(input logic [3:0] a, input logic csn, input logic exp_oe,
                           input logic [7:0] exp_d, input string req);
        set_addr(a);
        cs_n   = csn;
        strb_b = 1'b1;
        strb_a = 1'b0;
        @(negedge clk);
        check("R9 oe one edge after strobe", 32'(ad_oe), 32'd0);
        @(negedge clk);
        check("R7 oe during read", 32'(ad_oe), 32'(exp_oe));
        check(req, 32'(ad_out), exp_oe ? 32'(exp_d) : 32'd0);
        strb_a = 1'b1;
        @(negedge clk);
        check("R9 oe one edge after release", 32'(ad_oe), 32'(exp_oe));
        @(negedge clk);
        check("R9 oe two edges after release", 32'(ad_oe), 32'd0);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 oe low in reset", 32'(ad_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: control registers cleared after reset
        for (int a = 0; a < 12; a++) do_read(4'(a), 1'b0, 1'b1, 8'h00, "R1 reset value");

        for (int m = 0; m < 4; m++) begin
            bus_sel  = m[1];
            bus_type = m[0];
            repeat (2) @(negedge clk);
            // R3 R4 R5 R6 R8: full sweep of writes then readback
            for (int a = 0; a < 16; a++) do_write(4'(a), pat(m, a), 1'b0);
            for (int a = 0; a < 16; a++)
                do_read(4'(a), 1'b0, 1'b1, expect_rd(a),
                        m[0] ? "R4 moto readback R8" : "R3 intel readback R8");
            // R2: deselected write and read have no effect
            do_write(4'd3, 8'h5A ^ 8'(m), 1'b1);
            do_read(4'd3, 1'b1, 1'b0, 8'h00, "R2 deselected read");
            do_read(4'd3, 1'b0, 1'b1, expect_rd(3), "R2 deselected write ignored");
        end

        // R3: both Intel strobes low together is ignored
        bus_sel = 1'b1; bus_type = 1'b0;
        repeat (2) @(negedge clk);
        addr_in = 4'd6; ad_in = 8'hE7; cs_n = 1'b0;
        strb_a = 1'b0; strb_b = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 both low no oe", 32'(ad_oe), 32'd0);
        strb_a = 1'b1; strb_b = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        do_read(4'd6, 1'b0, 1'b1, expect_rd(6), "R3 both low no write");

        // R6: address strobe pulses in split mode do not move the address
        addr_in = 4'd2;
        ad_in = 8'h09; strb_c = 1'b1;
        repeat (2) @(negedge clk);
        strb_c = 1'b0;
        cs_n = 1'b0; strb_a = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 strb_c ignored in split mode", 32'(ad_out), 32'(expect_rd(2)));
        strb_a = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5: shared-bus address persists across accesses without a new latch
        bus_sel = 1'b0; bus_type = 1'b1;
        repeat (2) @(negedge clk);
        ad_in = 8'hF5; strb_c = 1'b1;
        @(negedge clk);
        strb_c = 1'b0;
        for (int k = 0; k < 2; k++) begin
            ad_in = 8'h0B; cs_n = 1'b0; strb_b = 1'b1; strb_a = 1'b0;
            repeat (2) @(negedge clk);
            check("R5 held address readback", 32'(ad_out), 32'(expect_rd(5)));
            strb_a = 1'b1; cs_n = 1'b1;
            repeat (3) @(negedge clk);
        end

        // R1: hardware reset mid-run clears control bytes, keeps status
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 oe low during reset", 32'(ad_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 12; i++) model[i] = 8'h00;
        bus_sel = 1'b1; bus_type = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 16; a++) do_read(4'(a), 1'b0, 1'b1, expect_rd(a), "R1 cleared after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule